// File: doc/BRIEF.md
# Four-Row Ping-Pong Block Averager

This block takes a raster stream of 8-bit pixels, with a start-of-frame strobe on the first pixel of a frame and an end-of-line strobe on the last pixel of each line. It reduces the image to one mean value per non-overlapping 4x4 tile. Incoming rows are stored in one of two banks. Each bank has four row memories, and each row memory holds one image line. When the fourth row of a group has been written, the banks trade roles. The next four rows fill the other bank while the completed group is read back.

Reading is done by a small state machine with two states. `RD_IDLE` waits for a completed group. The transition `start` (group complete) moves it to `RD_SCAN`. In `RD_SCAN` it reads one column of four pixels per cycle from the completed bank, one pixel from each row memory. The transition `last column` returns it to `RD_IDLE`. Four consecutive columns make one tile. Their 16 pixels are summed into a 12-bit total, and the total is shifted right by four to give the tile mean. Each result leaves the block with a one-cycle valid pulse, the tile's column index and the index of its four-row group within the frame. The line width is a parameter, and one instance handles one 8-bit channel.

Top module: `blkavg_top`

## Requirements
- R1: While reset is asserted and after its release, `cent_vld` is low until a result is produced; bank 0 receives the first rows after reset.
- R2: `cent_val` equals floor(S/16), where S is the sum of the 16 pixels of the tile, so truncation discards the four low bits; a tile of all 255 yields 255.
- R3: Tiles are non-overlapping 4x4 regions. Tile column k covers pixel columns 4k to 4k+3. Within a group, results are emitted for k = 0, 1, ..., WIDTH/4-1 in increasing order, and `cent_bcol` carries k.
- R4: `cent_brow` carries the index of the four-row group within the frame. Image rows 4g to 4g+3 form group g, and counting restarts at 0 on `sof`.
- R5: No result is emitted until a complete four-row group has been written, meaning the fourth `eol` of that group has been accepted.
- R6: While a completed group is read from one bank, incoming rows are written into the other bank without corrupting the results being read, even when pixels arrive on every cycle.
- R7: `cent_vld` is a single-cycle pulse, and the results of one group are spaced exactly four cycles apart.
- R8: A cycle with `pix_vld` low writes nothing; the value on `pix_in` then has no effect on any result.
- R9: `sof` restarts the column, row-in-group and group counters with the pixel that carries it, so a partly written group is discarded and produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_vld | input | 1 | Pixel qualifier |
| pix_in | input | PIX_W | Pixel value |
| sof | input | 1 | Marks the first pixel of a frame (with pix_vld) |
| eol | input | 1 | Marks the last pixel of a line (with pix_vld) |
| cent_vld | output | 1 | Tile mean valid pulse |
| cent_val | output | PIX_W | Tile mean |
| cent_bcol | output | $clog2(WIDTH)-2 | Tile column index |
| cent_brow | output | ROWG_W | Four-row group index within the frame |

## Verification
The assertions assume the following about the inputs. Every line carries exactly WIDTH valid pixels. `eol` is raised only on the last of them, and `sof` only on the first pixel of a frame. Pixels arrive at most one per cycle, so a group takes at least 4*WIDTH cycles to write, while a read pass takes about WIDTH cycles; this keeps the reader ahead of the writer. The stimulus drives full lines with `eol` at column WIDTH-1 and sets `sof` only at column 0. The one exception is a frame cut short after two rows, which is followed at once by a fresh `sof`. Idle cycles carry a junk pixel value, so that any stray write would show up in the results.

// File: rtl/blkavg_pkg.sv
package blkavg_pkg;
    typedef enum logic [0:0] {
        RD_IDLE = 1'b0,
        RD_SCAN = 1'b1
    } rd_state_t;
    localparam int ROWS_PER_GRP = 4;
    localparam int BANKS        = 2;
endpackage

// File: rtl/blkavg_rowram.sv
module blkavg_rowram #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/blkavg_wrctl.sv
module blkavg_wrctl #(
    parameter int WIDTH  = 32,
    parameter int ROWG_W = 8,
    localparam int COL_W = $clog2(WIDTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_vld,
    input  logic              sof,
    input  logic              eol,
    output logic [7:0]        row_we,
    output logic [COL_W-1:0]  waddr,
    output logic              grp_done,
    output logic              done_bank,
    output logic [ROWG_W-1:0] done_grp
);
    logic [COL_W-1:0]  col_q, col_eff;
    logic [1:0]        row_q, row_eff;
    logic [ROWG_W-1:0] grp_q, grp_eff;
    logic              bank_q;

    always_comb begin
        col_eff = sof ? '0 : col_q;
        row_eff = sof ? '0 : row_q;
        grp_eff = sof ? '0 : grp_q;
        waddr   = col_eff;
        row_we  = '0;
        if (pix_vld) row_we[{bank_q, row_eff}] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q     <= '0;
            row_q     <= '0;
            grp_q     <= '0;
            bank_q    <= 1'b0;
            grp_done  <= 1'b0;
            done_bank <= 1'b0;
            done_grp  <= '0;
        end else begin
            grp_done <= 1'b0;
            if (pix_vld) begin
                if (eol) begin
                    col_q <= '0;
                    if (row_eff == 2'd3) begin
                        row_q     <= '0;
                        bank_q    <= ~bank_q;
                        grp_q     <= grp_eff + 1'b1;
                        grp_done  <= 1'b1;
                        done_bank <= bank_q;
                        done_grp  <= grp_eff;
                    end else begin
                        row_q <= row_eff + 2'd1;
                        grp_q <= grp_eff;
                    end
                end else begin
                    col_q <= col_eff + 1'b1;
                    row_q <= row_eff;
                    grp_q <= grp_eff;
                end
            end
        end
    end
endmodule

// File: rtl/blkavg_rdpath.sv
module blkavg_rdpath
    import blkavg_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int PIX_W  = 8,
    parameter int ROWG_W = 8,
    localparam int COL_W  = $clog2(WIDTH),
    localparam int BCOL_W = COL_W - 2,
    localparam int SUM_W  = PIX_W + 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         start_bank,
    input  logic [ROWG_W-1:0]            start_grp,
    input  logic [1:0][3:0][PIX_W-1:0]   rdata,
    output logic                         rd_en,
    output logic [COL_W-1:0]             raddr,
    output logic                         cent_vld,
    output logic [PIX_W-1:0]             cent_val,
    output logic [BCOL_W-1:0]            cent_bcol,
    output logic [ROWG_W-1:0]            cent_brow
);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(WIDTH - 1);

    rd_state_t         state_q, state_d;
    logic [COL_W-1:0]  rcol_q;
    logic              rbank_q;
    logic [ROWG_W-1:0] rgrp_q;

    logic              p_vld;
    logic [COL_W-1:0]  p_col;
    logic              p_bank;
    logic [ROWG_W-1:0] p_grp;
    logic [SUM_W-1:0]  acc_q, colsum, tile_sum;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (start) state_d = RD_SCAN;
            RD_SCAN: if (rcol_q == LAST_COL) state_d = RD_IDLE;
            default: state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    assign rd_en = (state_q == RD_SCAN);
    assign raddr = rcol_q;

    always_comb begin
        colsum = '0;
        for (int r = 0; r < 4; r++) begin
            colsum = colsum + SUM_W'(rdata[p_bank][r]);
        end
        tile_sum = ((p_col[1:0] == 2'd0) ? '0 : acc_q) + colsum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rcol_q    <= '0;
            rbank_q   <= 1'b0;
            rgrp_q    <= '0;
            p_vld     <= 1'b0;
            p_col     <= '0;
            p_bank    <= 1'b0;
            p_grp     <= '0;
            acc_q     <= '0;
            cent_vld  <= 1'b0;
            cent_val  <= '0;
            cent_bcol <= '0;
            cent_brow <= '0;
        end else begin
            if (state_q == RD_IDLE && start) begin
                rcol_q  <= '0;
                rbank_q <= start_bank;
                rgrp_q  <= start_grp;
            end else if (state_q == RD_SCAN) begin
                rcol_q <= rcol_q + 1'b1;
            end
            p_vld  <= rd_en;
            p_col  <= rcol_q;
            p_bank <= rbank_q;
            p_grp  <= rgrp_q;
            if (p_vld) acc_q <= tile_sum;
            cent_vld <= p_vld && (p_col[1:0] == 2'd3);
            if (p_vld && (p_col[1:0] == 2'd3)) begin
                cent_val  <= tile_sum[SUM_W-1:4];
                cent_bcol <= p_col[COL_W-1:2];
                cent_brow <= p_grp;
            end
        end
    end
endmodule

// File: rtl/blkavg_top.sv
module blkavg_top #(
    parameter int WIDTH  = 32,
    parameter int PIX_W  = 8,
    parameter int ROWG_W = 8,
    localparam int COL_W  = $clog2(WIDTH),
    localparam int BCOL_W = COL_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_vld,
    input  logic [PIX_W-1:0]  pix_in,
    input  logic              sof,
    input  logic              eol,
    output logic              cent_vld,
    output logic [PIX_W-1:0]  cent_val,
    output logic [BCOL_W-1:0] cent_bcol,
    output logic [ROWG_W-1:0] cent_brow
);
    logic [7:0]                 row_we;
    logic [COL_W-1:0]           waddr, raddr;
    logic                       grp_done, done_bank, rd_en;
    logic [ROWG_W-1:0]          done_grp;
    logic [1:0][3:0][PIX_W-1:0] rdata;

    blkavg_wrctl #(.WIDTH(WIDTH), .ROWG_W(ROWG_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .sof(sof), .eol(eol),
        .row_we(row_we), .waddr(waddr), .grp_done(grp_done),
        .done_bank(done_bank), .done_grp(done_grp)
    );

    for (genvar b = 0; b < blkavg_pkg::BANKS; b++) begin : g_bank
        for (genvar r = 0; r < blkavg_pkg::ROWS_PER_GRP; r++) begin : g_row
            blkavg_rowram #(.DEPTH(WIDTH), .DW(PIX_W)) u_ram (
                .clk(clk), .we(row_we[b*4+r]), .waddr(waddr), .wdata(pix_in),
                .re(rd_en), .raddr(raddr), .rdata(rdata[b][r])
            );
        end
    end

    blkavg_rdpath #(.WIDTH(WIDTH), .PIX_W(PIX_W), .ROWG_W(ROWG_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .start(grp_done), .start_bank(done_bank),
        .start_grp(done_grp), .rdata(rdata), .rd_en(rd_en), .raddr(raddr),
        .cent_vld(cent_vld), .cent_val(cent_val), .cent_bcol(cent_bcol),
        .cent_brow(cent_brow)
    );
endmodule

// File: rtl/blkavg_chk.sv
module blkavg_chk #(
    parameter int WIDTH  = 32,
    parameter int ROWG_W = 8,
    localparam int BCOL_W = $clog2(WIDTH) - 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pix_vld,
    input logic              eol,
    input logic              cent_vld,
    input logic [BCOL_W-1:0] cent_bcol,
    input logic [ROWG_W-1:0] cent_brow
);
    localparam logic [BCOL_W-1:0] LAST_B = BCOL_W'(WIDTH / 4 - 1);

    logic [2:0]        eol_seen;
    logic              have_prev;
    logic [BCOL_W-1:0] prev_bcol;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eol_seen  <= '0;
            have_prev <= 1'b0;
            prev_bcol <= '0;
        end else begin
            if (pix_vld && eol && eol_seen != 3'd4) eol_seen <= eol_seen + 3'd1;
            if (cent_vld) begin
                have_prev <= 1'b1;
                prev_bcol <= cent_bcol;
            end
        end
    end

    always @(posedge clk) begin
        if (!rst_n) p_reset_quiet_r1: assert (!cent_vld);
    end

    p_no_early_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cent_vld |-> (eol_seen == 3'd4));

    p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cent_vld |=> !cent_vld);

    p_bcol_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cent_vld && have_prev && prev_bcol != LAST_B) |-> (cent_bcol == prev_bcol + 1'b1));

    p_bcol_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cent_vld && (!have_prev || prev_bcol == LAST_B)) |-> (cent_bcol == '0));

    p_bcol_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cent_vld |-> (cent_bcol <= LAST_B));

    p_brow_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cent_vld && have_prev && prev_bcol != LAST_B) |-> $stable(cent_brow));
endmodule

bind blkavg_top blkavg_chk #(.WIDTH(WIDTH), .ROWG_W(ROWG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .eol(eol),
    .cent_vld(cent_vld), .cent_bcol(cent_bcol), .cent_brow(cent_brow)
);

// File: tb/blkavg_tb.sv
module blkavg_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WIDTH  = 32;
    localparam int PIX_W  = 8;
    localparam int ROWG_W = 8;
    localparam int BCOL_W = $clog2(WIDTH) - 2;
    localparam int NB     = WIDTH / 4;
    localparam int NENT   = 6;
    // per entry: x slope, y slope, offset, noise on/off, idle gap
    localparam int TBL [0:NENT*5-1] = '{
        1, 0,   0, 0, 0,
        0, 0, 255, 0, 0,
        3, 5,  10, 1, 2,
        0, 16,  7, 1, 0,
        7, 1, 200, 1, 3,
        0, 0,   0, 0, 1
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic pix_vld = 1'b0, sof = 1'b0, eol = 1'b0;
    logic [PIX_W-1:0]  pix_in = '0;
    logic              cent_vld;
    logic [PIX_W-1:0]  cent_val;
    logic [BCOL_W-1:0] cent_bcol;
    logic [ROWG_W-1:0] cent_brow;

    int checks = 0, errors = 0, outs = 0, cycles = 0;
    int exp_val [0:511];
    int exp_bc  [0:511];
    int exp_br  [0:511];
    int exp_wr = 0, exp_rd = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blkavg_top #(.WIDTH(WIDTH), .PIX_W(PIX_W), .ROWG_W(ROWG_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .pix_in(pix_in),
        .sof(sof), .eol(eol), .cent_vld(cent_vld), .cent_val(cent_val),
        .cent_bcol(cent_bcol), .cent_brow(cent_brow)
    );

    function automatic int pixf(int e, int x, int y);
        int v;
        v = TBL[e*5]*x + TBL[e*5+1]*y + TBL[e*5+2];
        if (TBL[e*5+3] != 0) v = v + ((x*7 + y*13) % 17);
        return v & 255;
    endfunction

    task automatic check(string req, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic push_group(int e, int g);
        for (int bx = 0; bx < NB; bx++) begin
            int s;
            s = 0;
            for (int dy = 0; dy < 4; dy++)
                for (int dx = 0; dx < 4; dx++)
                    s += pixf(e, bx*4+dx, g*4+dy);
            exp_val[exp_wr] = s / 16;
            exp_bc[exp_wr]  = bx;
            exp_br[exp_wr]  = g;
            exp_wr++;
        end
    endtask

    task automatic send_row(int e, int y, bit first);
        int gap;
        gap = TBL[e*5+4];
        for (int x = 0; x < WIDTH; x++) begin
            if (gap > 0 && x == WIDTH/2) begin
                @(negedge clk);
                pix_vld = 1'b0; sof = 1'b0; eol = 1'b0; pix_in = 8'hA5;
            end
            @(negedge clk);
            pix_vld = 1'b1;
            pix_in  = PIX_W'(pixf(e, x, y));
            sof     = first && (x == 0);
            eol     = (x == WIDTH - 1);
        end
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            pix_vld = 1'b0; sof = 1'b0; eol = 1'b0; pix_in = 8'h5A;
        end
    endtask

    task automatic go_idle();
        @(negedge clk);
        pix_vld = 1'b0; sof = 1'b0; eol = 1'b0; pix_in = 8'hC3;
    endtask

    // monitor: R2 value, R3 column, R4 group, R5/R9 no stray output
    always @(negedge clk) begin
        if (rst_n && cent_vld) begin
            outs++;
            if (exp_rd >= exp_wr) begin
                checks++; errors++;
                $display("FAIL R5/R9 unexpected output actual=%0d expected=none", cent_val);
            end else begin
                check("R2 tile mean", int'(cent_val), exp_val[exp_rd]);
                check("R3 tile column", int'(cent_bcol), exp_bc[exp_rd]);
                check("R4 group index", int'(cent_brow), exp_br[exp_rd]);
                exp_rd++;
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                checks++; errors++;
                $display("FAIL watchdog actual=%0d expected<=100000", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid low in reset", int'(cent_vld), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 valid low after reset", int'(cent_vld), 0);

        // R5: three rows give nothing
        for (int y = 0; y < 3; y++) send_row(2, y, y == 0);
        go_idle();
        repeat (40) @(negedge clk);
        check("R5 no output before group complete", outs, 0);
        push_group(2, 0);
        send_row(2, 3, 1'b0);
        go_idle();
        repeat (WIDTH + 20) @(negedge clk);
        check("R5 R7 one group of results", outs, NB);

        // R9: partial group then restart via sof in the table loop
        send_row(2, 4, 1'b0);
        send_row(2, 5, 1'b0);

        // main vectors: R2 R3 R4 R6 R8
        for (int e = 0; e < NENT; e++) begin
            push_group(e, 0);
            push_group(e, 1);
            for (int y = 0; y < 8; y++) send_row(e, y, y == 0);
            go_idle();
            repeat (WIDTH + 20) @(negedge clk);
            check("R6 results drained per frame", exp_rd, exp_wr);
        end
        check("R9 total result count", outs, NB * (1 + 2*NENT));

        // R1 again: reset mid-stream clears output
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 valid low after re-reset", int'(cent_vld), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule